// File: doc/BRIEF.md
# Multi-Word Frame-Sync Serial Master

This block drives a codec-style synchronous serial link as the clock master. It divides the system clock down to a bit clock and marks the start of each frame with a one-bit-period frame-sync pulse. The frame length is programmable. Each frame carries a programmable number of fixed-width words. Transmit words are drawn from an internal transmit FIFO and shifted out on a serial data line, one word per slot, starting in the bit period that carries the sync pulse. Bit periods after the last word slot are driven as zero until the next frame begins.

In the same slots, the block assembles words from the serial input line and pushes them into an internal receive FIFO. Software-side logic fills the transmit FIFO and drains the receive FIFO through simple push/pop ports. Configuration is applied by a write strobe and is only accepted while the link is disabled. A typical setup is three 16-bit words, least significant bit first, in a 52-bit frame with an active-high sync.

Top module: `sync_frame_master`

## Requirements
- R1: The bit clock `sclk` has a period of 2*(`cfg_div`+1) system clocks while `enable` is high. It is held low while `enable` is low.
- R2: `fsync` is at its active level only during bit period 0 of each frame. The active level is high when `cfg_sync_high`=1 and low when it is 0. Otherwise `fsync` sits at the inactive level, including while disabled.
- R3: The effective frame length is the requested `cfg_frame_len`, raised to (`cfg_width_m1`+1)*(`cfg_words_m1`+1) if it is smaller, and capped at 64.
- R4: Word k occupies bit periods k*W to k*W+W-1 of the frame, where W = `cfg_width_m1`+1. With `cfg_lsb_first`=1, bit 0 of the word goes first; with 0, bit W-1 goes first. Every bit period after the last word slot drives `sdo` low.
- R5: `sdo` and `fsync` change only at the system clock edge where `sclk` rises.
- R6: `sdi` is sampled when `sclk` falls. The bits are assembled in the same bit order as transmit, and each completed word is pushed to the receive FIFO. `rx_data` shows the oldest word, and `rx_pop` removes it.
- R7: If the transmit FIFO is empty when a word slot starts, that slot sends zeros and `underrun` is set. `underrun` stays set until the next accepted configuration write.
- R8: If the receive FIFO is full when a word completes, the word is dropped and `overrun` is set. The FIFO keeps its earlier words. `overrun` stays set until the next accepted configuration write.
- R9: A `cfg_wr` while `enable` is high is ignored. The frame length and sync level stay as previously configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the transmit and receive paths |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_div | input | 8 | Half bit-clock period minus one, in system clocks |
| cfg_frame_len | input | 7 | Requested frame length in bit periods |
| cfg_width_m1 | input | 4 | Word width minus one |
| cfg_words_m1 | input | 2 | Words per frame minus one |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_sync_high | input | 1 | 1: frame-sync active high |
| tx_push | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 16 | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_empty | output | 1 | Receive FIFO empty |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| underrun | output | 1 | Sticky transmit underrun flag |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The in-line assertions watch, on every cycle, the following:
- `sdo` and `fsync` move only at a bit-clock rise.
- Tail periods stay low.
- Both sticky flags hold until a configuration write.
- A full receive FIFO never accepts a word.
- The configuration never changes while the link runs.

Only the bench scenarios can show the rest:
- Word placement and bit order in the stream.
- The effective frame length after clamping.
- The divider ratio.
- The contents of received words.
- Which word is lost on overrun.

They do this by comparing whole captured frames with values computed from the configuration.

// File: rtl/sfm_pkg.sv
// Shared constants and configuration type for the frame-sync serial master.
// Assumes at most MAX_WORDS words of at most DATA_W bits fit in MAX_FRAME.
package sfm_pkg;
    localparam int DATA_W    = 16;
    localparam int MAX_WORDS = 4;
    localparam int MAX_FRAME = 64;
    localparam int DIV_W     = 8;
    localparam int FIFO_DEPTH = 4;
    localparam int FRAME_W   = $clog2(MAX_FRAME + 1);
    localparam int POS_W     = $clog2(MAX_FRAME);
    localparam int BIT_W     = $clog2(DATA_W);
    localparam int WORD_W    = $clog2(MAX_WORDS);

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic [FRAME_W-1:0] frame_len;   // effective, already clamped
        logic [BIT_W-1:0]   width_m1;
        logic [WORD_W-1:0]  words_m1;
        logic               lsb_first;
        logic               sync_high;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{div: '0, frame_len: FRAME_W'(52),
                                     width_m1: BIT_W'(15), words_m1: WORD_W'(2),
                                     lsb_first: 1'b1, sync_high: 1'b1};
endpackage

// File: rtl/sfm_fifo.sv
// Small synchronous FIFO with a show-ahead output.
// Assumes DEPTH is a power of two of at least 2; push when full and pop when empty are dropped.
module sfm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(wr_ptr))); // R8
endmodule

// File: rtl/sfm_bitclk.sv
// Bit-clock generator: toggles sclk every (div+1) system clocks while run is high.
// Emits one-cycle rise/fall strobes on the system clock edge where sclk changes.
// Assumes div is stable while run is high.
module sfm_bitclk #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          sclk,
    output logic          rise_ev,
    output logic          fall_ev
);
    logic [DW-1:0] hcnt;
    logic          tick;

    assign tick    = run && (hcnt == div);
    assign rise_ev = tick && !sclk;
    assign fall_ev = tick && sclk;

    // Half-period counter and clock toggle; parked low when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hcnt <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            hcnt <= '0;
            sclk <= ~sclk;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfm_framer.sv
// Frame sequencer: tracks bit position, word slot and tail, serialises transmit
// words on bit-clock rises and assembles receive words on bit-clock falls.
// Assumes cfg is stable while run is high and frame_len already clamped.
module sfm_framer
    import sfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  cfg_t              cfg,
    input  logic              clr_flags,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              sdi,
    input  logic [DATA_W-1:0] tx_head,
    input  logic              tx_empty,
    input  logic              rx_full,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              sdo,
    output logic              fsync,
    output logic              underrun,
    output logic              overrun
);
    logic [POS_W-1:0]  pos_q, pos_n;
    logic [BIT_W-1:0]  bidx_q, bidx_n, tx_sel, rx_sel;
    logic [WORD_W-1:0] widx_q, widx_n;
    logic              tail_q, tail_n, last_pos, slot_start, word_done;
    logic [DATA_W-1:0] tx_word_q, cur_word, rx_acc_q;

    // Next bit position, bit index, word index and tail flag.
    always_comb begin
        last_pos = ({1'b0, pos_q} == cfg.frame_len - FRAME_W'(1));
        pos_n  = pos_q + 1'b1;
        bidx_n = bidx_q;
        widx_n = widx_q;
        tail_n = tail_q;
        if (last_pos) begin
            pos_n  = '0;
            bidx_n = '0;
            widx_n = '0;
            tail_n = 1'b0;
        end else if (!tail_q) begin
            if (bidx_q == cfg.width_m1) begin
                bidx_n = '0;
                if (widx_q == cfg.words_m1) tail_n = 1'b1;
                else                        widx_n = widx_q + 1'b1;
            end else begin
                bidx_n = bidx_q + 1'b1;
            end
        end
    end

    // Transmit word selection and bit pick.
    assign slot_start = !tail_n && (bidx_n == '0);
    assign cur_word   = slot_start ? (tx_empty ? '0 : tx_head) : tx_word_q;
    assign tx_sel     = cfg.lsb_first ? bidx_n : cfg.width_m1 - bidx_n;
    assign tx_pop     = rise_ev && slot_start && !tx_empty;

    // Sequencer state and launched outputs, updated on bit-clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= POS_W'(CFG_DEFAULT.frame_len - FRAME_W'(1));
            bidx_q    <= '0;
            widx_q    <= '0;
            tail_q    <= 1'b1;
            tx_word_q <= '0;
            sdo       <= 1'b0;
            fsync     <= 1'b0;
        end else if (!run) begin
            pos_q  <= POS_W'(cfg.frame_len - FRAME_W'(1));
            bidx_q <= '0;
            widx_q <= '0;
            tail_q <= 1'b1;
            sdo    <= 1'b0;
            fsync  <= !cfg.sync_high;
        end else if (rise_ev) begin
            pos_q     <= pos_n;
            bidx_q    <= bidx_n;
            widx_q    <= widx_n;
            tail_q    <= tail_n;
            tx_word_q <= cur_word;
            sdo       <= tail_n ? 1'b0 : cur_word[tx_sel];
            fsync     <= cfg.sync_high ? (pos_n == '0) : (pos_n != '0);
        end
    end

    // Receive bit placement into the word being assembled.
    assign rx_sel = cfg.lsb_first ? bidx_q : cfg.width_m1 - bidx_q;
    always_comb begin
        rx_word         = (bidx_q == '0) ? '0 : rx_acc_q;
        rx_word[rx_sel] = sdi;
    end
    assign word_done = fall_ev && !tail_q && (bidx_q == cfg.width_m1);
    assign rx_push   = word_done && !rx_full;

    // Receive accumulator, updated on bit-clock falls inside a word slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rx_acc_q <= '0;
        else if (fall_ev && !tail_q)  rx_acc_q <= rx_word;
    end

    // Sticky error flags, cleared by an accepted configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_flags) begin
            underrun <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (rise_ev && slot_start && tx_empty) underrun <= 1'b1;
            if (word_done && rx_full)              overrun  <= 1'b1;
        end
    end

    AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable({sdo, fsync})) |-> $past(rise_ev)); // R5
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tail_q |-> !sdo); // R4
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr_flags) |=> underrun); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_flags) |=> overrun); // R8
endmodule

// File: rtl/sync_frame_master.sv
// Top of the frame-sync serial master: configuration capture with clamping,
// bit-clock generator, frame sequencer and the two word FIFOs.
// Assumes configuration is written only while enable is low; other writes are dropped.
module sync_frame_master
    import sfm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_wr,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [FRAME_W-1:0] cfg_frame_len,
    input  logic [BIT_W-1:0]   cfg_width_m1,
    input  logic [WORD_W-1:0]  cfg_words_m1,
    input  logic               cfg_lsb_first,
    input  logic               cfg_sync_high,
    input  logic               tx_push,
    input  logic [DATA_W-1:0]  tx_data,
    output logic               tx_full,
    input  logic               rx_pop,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_empty,
    output logic               sclk,
    output logic               fsync,
    output logic               sdo,
    input  logic               sdi,
    output logic               underrun,
    output logic               overrun
);
    cfg_t               cfg_q, cfg_in;
    logic               cfg_take, rise_ev, fall_ev, tx_pop, tx_empty, rx_push, rx_full;
    logic [FRAME_W-1:0] min_len;
    logic [DATA_W-1:0]  tx_head, rx_word;

    // Clamp the requested frame length between the word payload and the maximum.
    always_comb begin
        min_len = FRAME_W'((FRAME_W'(cfg_width_m1) + FRAME_W'(1)) *
                           (FRAME_W'(cfg_words_m1) + FRAME_W'(1)));
        cfg_in = '{div: cfg_div, frame_len: cfg_frame_len, width_m1: cfg_width_m1,
                   words_m1: cfg_words_m1, lsb_first: cfg_lsb_first,
                   sync_high: cfg_sync_high};
        if (cfg_frame_len < min_len)                    cfg_in.frame_len = min_len;
        else if (cfg_frame_len > FRAME_W'(MAX_FRAME))   cfg_in.frame_len = FRAME_W'(MAX_FRAME);
    end

    assign cfg_take = cfg_wr && !enable;

    // Configuration register, written only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= CFG_DEFAULT;
        else if (cfg_take) cfg_q <= cfg_in;
    end

    sfm_bitclk #(.DW(DIV_W)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .run(enable), .div(cfg_q.div),
        .sclk(sclk), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    sfm_framer u_framer (
        .clk(clk), .rst_n(rst_n), .run(enable), .cfg(cfg_q), .clr_flags(cfg_take),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .sdi(sdi),
        .tx_head(tx_head), .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sdo(sdo), .fsync(fsync), .underrun(underrun), .overrun(overrun)
    );

    sfm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data), .pop(tx_pop),
        .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    sfm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rx_pop),
        .dout(rx_data), .full(rx_full), .empty(rx_empty)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_q)); // R9
endmodule

// File: tb/sync_frame_master_tb_top.sv
module sync_frame_master_tb_top;
    import sfm_pkg::*;

    typedef struct packed {
        logic [7:0]        div;
        logic [6:0]        flen;
        logic [3:0]        wm1;
        logic [1:0]        cm1;
        logic              lsb;
        logic              sh;
        logic [3:0][15:0]  t;
        logic [3:0][15:0]  r;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{div: 8'd0, flen: 7'd52, wm1: 4'd15, cm1: 2'd2, lsb: 1'b1, sh: 1'b1,
          t: {16'h0, 16'hFFFF, 16'h1234, 16'hA5C3}, r: {16'h0, 16'h0F0F, 16'hBEEF, 16'h8001}},
        '{div: 8'd2, flen: 7'd20, wm1: 4'd7, cm1: 2'd1, lsb: 1'b0, sh: 1'b0,
          t: {16'h0, 16'h0, 16'h003A, 16'h00C5}, r: {16'h0, 16'h0, 16'h00E1, 16'h0096}},
        '{div: 8'd1, flen: 7'd5, wm1: 4'd3, cm1: 2'd3, lsb: 1'b1, sh: 1'b1,
          t: {16'h1, 16'hF, 16'h6, 16'h9}, r: {16'hC, 16'h3, 16'h5, 16'hA}},
        '{div: 8'd0, flen: 7'd100, wm1: 4'd11, cm1: 2'd0, lsb: 1'b0, sh: 1'b1,
          t: {16'h0, 16'h0, 16'h0, 16'h0ABC}, r: {16'h0, 16'h0, 16'h0, 16'h0123}}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0, enable = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic [6:0]  cfg_frame_len = '0;
    logic [3:0]  cfg_width_m1 = '0;
    logic [1:0]  cfg_words_m1 = '0;
    logic        cfg_lsb_first = 1'b1, cfg_sync_high = 1'b1;
    logic        tx_push = 1'b0, rx_pop = 1'b0, sdi = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_full, rx_empty, sclk, fsync, sdo, underrun, overrun;
    logic [15:0] rx_data;

    sync_frame_master dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
        .cfg_frame_len(cfg_frame_len), .cfg_width_m1(cfg_width_m1),
        .cfg_words_m1(cfg_words_m1), .cfg_lsb_first(cfg_lsb_first),
        .cfg_sync_high(cfg_sync_high), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
        .sclk(sclk), .fsync(fsync), .sdo(sdo), .sdi(sdi),
        .underrun(underrun), .overrun(overrun)
    );

    int checks = 0, errors = 0, cyc = 0;
    logic sdo_a [128];
    logic fs_a  [128];
    int   rc_a  [128];
    logic sdi_a [128];

    always @(negedge clk) cyc++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired");
                summary();
            end
        end
    end

    task automatic cfgw(input logic [7:0] d, input logic [6:0] fl, input logic [3:0] w,
                        input logic [1:0] c, input logic l, input logic s);
        cfg_div = d; cfg_frame_len = fl; cfg_width_m1 = w; cfg_words_m1 = c;
        cfg_lsb_first = l; cfg_sync_high = s; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input logic [15:0] d);
        tx_data = d; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_chk(input string req, input int exp);
        chk(req, int'(rx_data), exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic drain();
        while (!rx_empty) begin
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
    endtask

    // Enables the link, records n bit-clock rises, drives sdi per bit, then disables.
    task automatic run_bits(input int n);
        logic prev;
        prev = sclk;
        enable = 1'b1;
        for (int i = 0; i < n;) begin
            @(negedge clk);
            if (sclk && !prev) begin
                sdo_a[i] = sdo; fs_a[i] = fsync; rc_a[i] = cyc; sdi = sdi_a[i];
                i++;
                if (i == n) enable = 1'b0;
            end
            prev = sclk;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic slot_bit(input logic [3:0][15:0] ws, input int wd,
                                      input int cnt, input logic lsb, input int p);
        int k, b;
        if (p >= wd * cnt) return 1'b0;
        k = p / wd;
        b = p % wd;
        return lsb ? ws[k][b] : ws[k][wd - 1 - b];
    endfunction

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset sclk", sclk, 0);
        chk("R2 reset fsync", fsync, 0);
        chk("R4 reset sdo", sdo, 0);
        chk("R6 reset rx_empty", rx_empty, 1);
        chk("R7 reset underrun", underrun, 0);
        chk("R8 reset overrun", overrun, 0);
        chk("reset tx_full", tx_full, 0);

        // Vector table walk
        for (int v = 0; v < 4; v++) begin
            int wd, cnt, eff, nbad, fbad;
            vec_t cv;
            cv = VEC[v];
            wd = int'(cv.wm1) + 1;
            cnt = int'(cv.cm1) + 1;
            eff = (int'(cv.flen) < wd * cnt) ? wd * cnt : ((cv.flen > 64) ? 64 : int'(cv.flen));
            cfgw(cv.div, cv.flen, cv.wm1, cv.cm1, cv.lsb, cv.sh);
            for (int k = 0; k < cnt; k++) push(cv.t[k]);
            for (int p = 0; p < 128; p++) sdi_a[p] = slot_bit(cv.r, wd, cnt, cv.lsb, p);
            run_bits(eff + 1);
            nbad = 0;
            fbad = 0;
            for (int p = 0; p < eff; p++)
                if (sdo_a[p] !== slot_bit(cv.t, wd, cnt, cv.lsb, p)) nbad++;
            for (int p = 0; p <= eff; p++)
                if (fs_a[p] !== (((p == 0) || (p == eff)) ? cv.sh : !cv.sh)) fbad++;
            chk("R4 sdo bit mismatches", nbad, 0);
            chk("R2 R3 fsync position/length mismatches", fbad, 0);
            chk("R1 bit period", rc_a[1] - rc_a[0], 2 * (int'(cv.div) + 1));
            chk("R1 idle sclk", sclk, 0);
            chk("R2 idle fsync", fsync, !cv.sh);
            for (int k = 0; k < cnt; k++)
                pop_chk("R6 rx word", int'(cv.r[k] & (16'hFFFF >> (16 - wd))));
            chk("R6 rx drained", rx_empty, 1);
        end

        // R9: config write while enabled is dropped
        cfgw(8'd0, 7'd52, 4'd15, 2'd2, 1'b1, 1'b1);
        enable = 1'b1;
        repeat (5) @(negedge clk);
        cfg_frame_len = 7'd10; cfg_sync_high = 1'b0; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (4) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 idle fsync keeps old polarity", fsync, 0);
        for (int p = 0; p < 128; p++) sdi_a[p] = 1'b0;
        run_bits(53);
        chk("R9 fsync at bit 0", fs_a[0], 1);
        chk("R9 no fsync at bit 10", fs_a[10], 0);
        chk("R9 fsync at bit 52", fs_a[52], 1);
        drain();

        // R7: empty transmit FIFO sends zeros and sets the sticky flag
        cfgw(8'd0, 7'd8, 4'd3, 2'd0, 1'b1, 1'b1);
        chk("R7 flag cleared by config write", underrun, 0);
        for (int p = 0; p < 128; p++) sdi_a[p] = 1'b1;
        run_bits(8);
        begin
            int ones;
            ones = 0;
            for (int p = 0; p < 8; p++) if (sdo_a[p]) ones++;
            chk("R7 zero slot on underrun", ones, 0);
        end
        chk("R7 underrun set", underrun, 1);
        drain();

        // R8: full receive FIFO drops the fifth word; payload clamp gives 4-bit frame
        cfgw(8'd0, 7'd0, 4'd0, 2'd3, 1'b1, 1'b1);
        chk("R8 overrun clear before", overrun, 0);
        push(16'h1); push(16'h0); push(16'h1); push(16'h1);
        sdi_a[0] = 1'b1; sdi_a[1] = 1'b0; sdi_a[2] = 1'b0; sdi_a[3] = 1'b1;
        sdi_a[4] = 1'b0; sdi_a[5] = 1'b0;
        run_bits(6);
        chk("R3 clamp fsync at bit 4", fs_a[4], 1);
        chk("R3 clamp no fsync at bit 3", fs_a[3], 0);
        chk("R4 1-bit words", {sdo_a[0], sdo_a[1], sdo_a[2], sdo_a[3]}, 4'b1011);
        chk("R8 overrun set", overrun, 1);
        pop_chk("R8 kept word 0", 1);
        pop_chk("R8 kept word 1", 0);
        pop_chk("R8 kept word 2", 0);
        pop_chk("R8 kept word 3", 1);
        chk("R8 dropped word absent", rx_empty, 1);

        summary();
    end
endmodule